// File: doc/BRIEF.md
# Thread Interrupt Steering and Reschedule Unit

This unit sits between a core's external interrupt lines and its hardware threads. It picks which thread takes each incoming interrupt. Each request is held pending until it is served. On every cycle the unit looks at the pending sources and at the live state of each thread: its priority, its enable, its per-source mask and whether it is already handling an exception. It then grants the lowest pending source that some thread can accept. The grant goes to the eligible thread whose priority is lowest, and that thread gets a one-cycle take pulse. Any thread may serve any source; the choice depends only on its current state.

The unit also helps an operating-system scheduler. Software programs a best-waiting priority: the priority of the most urgent task that is ready but not running. While scheduler assistance is switched on, the unit raises a one-cycle reschedule interrupt whenever some thread runs at a priority worse than that value. When it fires, it reloads the best-waiting value with all ones. That value is worse than any thread priority, so the interrupt does not fire again until software writes a new value.

Top module: `irq_steer`

## Requirements
- R1: A thread can take a source only when all four conditions hold: the global enable is high, the thread's own enable is high, the thread's mask bit for that source (bit `t*NSRC+s` of the mask bus, 1 = masked) is clear, and the thread is not in exception state.
- R2: Thread priorities are 8-bit and a larger value means a lower priority. Among the threads eligible for the granted source, the one with the largest value wins. On a tie, the lowest thread index wins.
- R3: A grant is a one-hot, one-cycle pulse on `take_o`, with the source number on `take_src_o`. It appears on the clock edge after the edge that sampled the request, provided the source is served at once.
- R4: A grant sets the chosen thread's exception state (`thr_exc_o`) on the same edge. A pulse on that thread's `thr_exdone_i` bit clears the state on the next edge.
- R5: A request stays pending until it is granted. Among pending sources that have at least one eligible thread, the lowest index is served first. A source with no eligible thread is skipped and stays pending, and it is served once a thread becomes eligible.
- R6: While `sched_en_i` is low, no reschedule interrupt is raised and the best-waiting value changes only by a software write.
- R7: While `sched_en_i` is high, `resched_o` pulses for one cycle on the edge after any thread's priority, zero-extended to 9 bits, is strictly greater than the best-waiting value. Equal values do not fire.
- R8: When the reschedule interrupt fires, the best-waiting value becomes 0x1ff. If a software write lands on the same edge, the written value is kept instead.
- R9: After reset there is no grant, no thread is in exception state, nothing is pending, `resched_o` is low and the best-waiting value is 0x1ff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie_i | input | 1 | Global interrupt enable |
| thr_ie_i | input | NT | Per-thread interrupt enable |
| thr_prio_i | input | NT*PW | Per-thread priority, thread t at bits t*PW +: PW |
| thr_imask_i | input | NT*NSRC | Per-thread source mask, 1 = masked |
| thr_exdone_i | input | NT | Per-thread pulse that clears exception state |
| irq_i | input | NSRC | External interrupt request pulses |
| sched_en_i | input | 1 | Scheduler assistance enable |
| bw_we_i | input | 1 | Write strobe for the best-waiting value |
| bw_wdata_i | input | BWW | Best-waiting value to write |
| take_o | output | NT | One-hot interrupt take pulse |
| take_src_o | output | SRCW | Source number of the current take |
| thr_exc_o | output | NT | Per-thread exception state |
| resched_o | output | 1 | Reschedule interrupt pulse |
| bestwait_o | output | BWW | Current best-waiting value |

## Verification
The assertions assume that the thread inputs are held steady around a clock edge and that an exception-clear pulse is never aimed at a thread on the cycle it is being granted. They also assume that reset is applied while `bw_we_i` and `sched_en_i` are low, so the write-precedence check has a defined past value. The stimulus changes every input only on falling edges. It issues exception clears only after the scoreboard has seen the expected grants, and it keeps reset with all enables at zero for several cycles before any traffic.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    parameter int unsigned DEF_NT   = 4;
    parameter int unsigned DEF_NSRC = 8;
    parameter int unsigned DEF_PW   = 8;
    parameter int unsigned DEF_BWW  = 9;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic [1:0] {
        BW_HOLD   = 2'd0,
        BW_WRITE  = 2'd1,
        BW_RELOAD = 2'd2
    } bw_action_e;

endpackage

// File: rtl/steer_elig.sv
module steer_elig #(
    parameter int unsigned NT   = irq_steer_pkg::DEF_NT,
    parameter int unsigned NSRC = irq_steer_pkg::DEF_NSRC
) (
    input  logic               gie,
    input  logic [NT-1:0]      thr_ie,
    input  logic [NT-1:0]      thr_exc,
    input  logic [NT*NSRC-1:0] thr_imask,
    input  logic [NSRC-1:0]    pend,
    output logic [NSRC*NT-1:0] elig
);
    // elig bit s*NT+t: source s may be handed to thread t
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar t = 0; t < NT; t++) begin : g_thr
            assign elig[s*NT+t] = gie && pend[s] && thr_ie[t]
                                  && !thr_exc[t] && !thr_imask[t*NSRC+s];
        end
    end
endmodule

// File: rtl/steer_pick.sv
module steer_pick #(
    parameter int unsigned NT = irq_steer_pkg::DEF_NT,
    parameter int unsigned PW = irq_steer_pkg::DEF_PW,
    localparam int unsigned TIDW = irq_steer_pkg::idx_w(NT)
) (
    input  logic [NT-1:0]    cand,
    input  logic [NT*PW-1:0] prio,
    output logic             found,
    output logic [TIDW-1:0]  tid
);
    logic [PW-1:0] best_p;

    // largest value = lowest priority; strict compare keeps lowest index on ties
    always_comb begin
        found  = 1'b0;
        tid    = '0;
        best_p = '0;
        for (int t = 0; t < NT; t++) begin
            if (cand[t] && (!found || prio[t*PW +: PW] > best_p)) begin
                found  = 1'b1;
                tid    = TIDW'(t);
                best_p = prio[t*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/steer_resched.sv
module steer_resched #(
    parameter int unsigned NT  = irq_steer_pkg::DEF_NT,
    parameter int unsigned PW  = irq_steer_pkg::DEF_PW,
    parameter int unsigned BWW = irq_steer_pkg::DEF_BWW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sched_en,
    input  logic [NT*PW-1:0] prio,
    input  logic             bw_we,
    input  logic [BWW-1:0]   bw_wdata,
    output logic             resched,
    output logic [BWW-1:0]   bestwait
);
    import irq_steer_pkg::*;

    localparam logic [BWW-1:0] BW_IDLE = {BWW{1'b1}};

    logic [NT-1:0] worse;
    logic          fire;
    bw_action_e    act;

    for (genvar t = 0; t < NT; t++) begin : g_cmp
        assign worse[t] = BWW'(prio[t*PW +: PW]) > bestwait;
    end

    assign fire = sched_en && (|worse);

    always_comb begin
        if (bw_we)     act = BW_WRITE;
        else if (fire) act = BW_RELOAD;
        else           act = BW_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bestwait <= BW_IDLE;
            resched  <= 1'b0;
        end else begin
            resched <= fire;
            case (act)
                BW_WRITE:  bestwait <= bw_wdata;
                BW_RELOAD: bestwait <= BW_IDLE;
                default:   bestwait <= bestwait;
            endcase
        end
    end
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
    parameter int unsigned NT   = irq_steer_pkg::DEF_NT,
    parameter int unsigned NSRC = irq_steer_pkg::DEF_NSRC,
    parameter int unsigned PW   = irq_steer_pkg::DEF_PW,
    parameter int unsigned BWW  = irq_steer_pkg::DEF_BWW,
    localparam int unsigned TIDW = irq_steer_pkg::idx_w(NT),
    localparam int unsigned SRCW = irq_steer_pkg::idx_w(NSRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gie_i,
    input  logic [NT-1:0]      thr_ie_i,
    input  logic [NT*PW-1:0]   thr_prio_i,
    input  logic [NT*NSRC-1:0] thr_imask_i,
    input  logic [NT-1:0]      thr_exdone_i,
    input  logic [NSRC-1:0]    irq_i,
    input  logic               sched_en_i,
    input  logic               bw_we_i,
    input  logic [BWW-1:0]     bw_wdata_i,
    output logic [NT-1:0]      take_o,
    output logic [SRCW-1:0]    take_src_o,
    output logic [NT-1:0]      thr_exc_o,
    output logic               resched_o,
    output logic [BWW-1:0]     bestwait_o
);
    typedef struct packed {
        logic            valid;
        logic [SRCW-1:0] src;
        logic [TIDW-1:0] tid;
    } grant_t;

    logic [NSRC-1:0]    pend_q;
    logic [NT-1:0]      exc_q;
    logic [NSRC*NT-1:0] elig;
    logic [NSRC-1:0]    src_ok;
    logic [TIDW-1:0]    src_tid [NSRC];
    grant_t             grant;
    logic [NT-1:0]      take_d;
    logic [NSRC-1:0]    serve_clr;

    steer_elig #(.NT(NT), .NSRC(NSRC)) elig_i (
        .gie       (gie_i),
        .thr_ie    (thr_ie_i),
        .thr_exc   (exc_q),
        .thr_imask (thr_imask_i),
        .pend      (pend_q),
        .elig      (elig)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_pick
        steer_pick #(.NT(NT), .PW(PW)) pick_i (
            .cand  (elig[s*NT +: NT]),
            .prio  (thr_prio_i),
            .found (src_ok[s]),
            .tid   (src_tid[s])
        );
    end

    // lowest serviceable source wins
    always_comb begin
        grant = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (src_ok[s]) begin
                grant.valid = 1'b1;
                grant.src   = SRCW'(s);
                grant.tid   = src_tid[s];
            end
        end
    end

    always_comb begin
        take_d    = '0;
        serve_clr = '0;
        if (grant.valid) begin
            take_d[grant.tid]    = 1'b1;
            serve_clr[grant.src] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            exc_q      <= '0;
            take_o     <= '0;
            take_src_o <= '0;
        end else begin
            pend_q     <= (pend_q & ~serve_clr) | irq_i;
            exc_q      <= (exc_q & ~thr_exdone_i) | take_d;
            take_o     <= take_d;
            take_src_o <= grant.valid ? grant.src : '0;
        end
    end

    assign thr_exc_o = exc_q;

    steer_resched #(.NT(NT), .PW(PW), .BWW(BWW)) resched_i (
        .clk      (clk),
        .rst      (rst),
        .sched_en (sched_en_i),
        .prio     (thr_prio_i),
        .bw_we    (bw_we_i),
        .bw_wdata (bw_wdata_i),
        .resched  (resched_o),
        .bestwait (bestwait_o)
    );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
    parameter int unsigned NT  = irq_steer_pkg::DEF_NT,
    parameter int unsigned BWW = irq_steer_pkg::DEF_BWW
) (
    input logic           clk,
    input logic           rst,
    input logic           gie_i,
    input logic           sched_en_i,
    input logic           bw_we_i,
    input logic [NT-1:0]  take_o,
    input logic [NT-1:0]  thr_exc_o,
    input logic           resched_o,
    input logic [BWW-1:0] bestwait_o
);
    a_r3_take_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_o));

    a_r4_take_sets_exc: assert property (@(posedge clk) disable iff (rst)
        (take_o != '0) |-> ((take_o & thr_exc_o) == take_o));

    a_r1_no_take_in_exc: assert property (@(posedge clk) disable iff (rst)
        (take_o != '0) |-> (($past(thr_exc_o) & take_o) == '0));

    a_r1_gie_blocks: assert property (@(posedge clk) disable iff (rst)
        !gie_i |=> (take_o == '0));

    a_r6_no_resched_disabled: assert property (@(posedge clk) disable iff (rst)
        !sched_en_i |=> !resched_o);

    a_r8_bw_reload: assert property (@(posedge clk) disable iff (rst)
        (resched_o && !$past(bw_we_i)) |-> (bestwait_o == {BWW{1'b1}}));
endmodule

bind irq_steer irq_steer_chk #(.NT(NT), .BWW(BWW)) chk_i (.*);

// File: tb/irq_steer_tb_top.sv
`timescale 1ns/1ps
module irq_steer_tb_top;
    localparam int NT = 4, NSRC = 8, PW = 8, BWW = 9, SRCW = 3;

    logic               clk = 0;
    logic               rst = 1;
    logic               gie_i = 0;
    logic [NT-1:0]      thr_ie_i = '0;
    logic [NT*PW-1:0]   thr_prio_i = '0;
    logic [NT*NSRC-1:0] thr_imask_i = '0;
    logic [NT-1:0]      thr_exdone_i = '0;
    logic [NSRC-1:0]    irq_i = '0;
    logic               sched_en_i = 0;
    logic               bw_we_i = 0;
    logic [BWW-1:0]     bw_wdata_i = '0;
    logic [NT-1:0]      take_o;
    logic [SRCW-1:0]    take_src_o;
    logic [NT-1:0]      thr_exc_o;
    logic               resched_o;
    logic [BWW-1:0]     bestwait_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    irq_steer dut_i (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard item: thread*16 + source
    task automatic expect_take(input int thr, input int src);
        exp_q.push_back(thr * 16 + src);
    endtask

    always @(negedge clk) begin
        if (!rst && take_o != '0) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1/R5 unexpected take: actual take=0x%0h src=%0d expected none",
                         take_o, take_src_o);
            end else begin
                int item;
                item = exp_q.pop_front();
                check({28'd0, take_o}, 32'(1) << (item / 16), "R2/R3 take thread");
                check({29'd0, take_src_o}, 32'(item % 16), "R3/R5 take source");
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(input logic [NSRC-1:0] m);
        @(negedge clk); irq_i = m;
        @(negedge clk); irq_i = '0;
    endtask

    task automatic clear_exc();
        @(negedge clk); thr_exdone_i = '1;
        @(negedge clk); thr_exdone_i = '0;
    endtask

    task automatic bw_write(input logic [BWW-1:0] v);
        @(negedge clk); bw_we_i = 1; bw_wdata_i = v;
        @(negedge clk); bw_we_i = 0;
    endtask

    task automatic set_prio(input int t, input int v);
        thr_prio_i[t*PW +: PW] = PW'(v);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        // R9 reset state
        check({28'd0, take_o}, 0, "R9 take after reset");
        check({28'd0, thr_exc_o}, 0, "R9 exc after reset");
        check({31'd0, resched_o}, 0, "R9 resched after reset");
        check({23'd0, bestwait_o}, 32'h1ff, "R9 bestwait after reset");
        @(negedge clk); rst = 0;
        set_prio(0, 10); set_prio(1, 40); set_prio(2, 40); set_prio(3, 20);
        thr_ie_i = '1; gie_i = 1;

        // R2 lowest priority, tie -> lowest index; R4 exception set
        expect_take(1, 2);
        pulse_irq(8'h04);
        cyc(2);
        check({28'd0, thr_exc_o}, 4'b0010, "R4 exc set by take");
        clear_exc();
        check({28'd0, thr_exc_o}, 0, "R4 exc cleared by done");

        // R1 thread in exception is skipped
        expect_take(1, 0);
        pulse_irq(8'h01);
        expect_take(2, 1);
        pulse_irq(8'h02);
        cyc(2);
        check({28'd0, thr_exc_o}, 4'b0110, "R1 exc threads skipped");
        clear_exc();

        // R1 mask
        thr_imask_i[1*NSRC+5] = 1; thr_imask_i[2*NSRC+5] = 1;
        expect_take(3, 5);
        pulse_irq(8'h20);
        cyc(2);
        thr_imask_i = '0;
        clear_exc();

        // R5 two sources together, lowest first
        expect_take(1, 3);
        expect_take(2, 6);
        pulse_irq(8'h48);
        cyc(3);
        check({28'd0, thr_exc_o}, 4'b0110, "R5 both served");
        clear_exc();

        // R1 global enable low: held pending, no take
        gie_i = 0;
        pulse_irq(8'h10);
        cyc(4);
        check({28'd0, thr_exc_o}, 0, "R1 gie low no take");
        expect_take(1, 4);
        gie_i = 1;
        cyc(2);
        check(32'(exp_q.size()), 0, "R5 pending served after enable");
        clear_exc();

        // R1 per-thread enable
        thr_ie_i = 4'b1101;
        expect_take(2, 0);
        pulse_irq(8'h01);
        cyc(2);
        thr_ie_i = '1;
        clear_exc();

        // R5 blocked source skipped, stays pending
        for (int t = 0; t < NT; t++) thr_imask_i[t*NSRC+1] = 1;
        expect_take(1, 7);
        pulse_irq(8'h82);
        cyc(3);
        check({28'd0, thr_exc_o}, 4'b0010, "R5 blocked source skipped");
        clear_exc();
        cyc(2);
        check({28'd0, thr_exc_o}, 0, "R5 masked source not taken");
        expect_take(1, 1);
        thr_imask_i = '0;
        cyc(2);
        check(32'(exp_q.size()), 0, "R5 blocked source served later");
        clear_exc();

        // R6 scheduler disabled
        bw_write(9'h020);
        cyc(3);
        check({31'd0, resched_o}, 0, "R6 no resched when disabled");
        check({23'd0, bestwait_o}, 32'h020, "R6 bestwait kept");
        // R7/R8 fire and reload
        sched_en_i = 1;
        @(negedge clk);
        check({31'd0, resched_o}, 1, "R7 resched fires");
        check({23'd0, bestwait_o}, 32'h1ff, "R8 reload to 0x1ff");
        @(negedge clk);
        check({31'd0, resched_o}, 0, "R7 one-cycle pulse");
        // R7 equal is not worse
        bw_write(9'h028);
        cyc(2);
        check({31'd0, resched_o}, 0, "R7 equal does not fire");
        check({23'd0, bestwait_o}, 32'h028, "R7 bestwait equal kept");
        bw_write(9'h027);
        check({31'd0, resched_o}, 0, "R7 not yet");
        @(negedge clk);
        check({31'd0, resched_o}, 1, "R7 strict worse fires");
        check({23'd0, bestwait_o}, 32'h1ff, "R8 reload after strict");
        // R8 write wins over reload
        @(negedge clk); bw_we_i = 1; bw_wdata_i = 9'h010;
        @(negedge clk); bw_wdata_i = 9'h030;
        @(negedge clk); bw_we_i = 0;
        check({31'd0, resched_o}, 1, "R8 fire with write");
        check({23'd0, bestwait_o}, 32'h030, "R8 write has precedence");
        cyc(2);
        check({31'd0, resched_o}, 0, "R7 no fire when none worse");
        sched_en_i = 0;

        cyc(2);
        check(32'(exp_q.size()), 0, "R3 scoreboard drained");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule